// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Generator

This block drives two complementary PWM outputs from a counter that counts up and then down. The counter advances once per prescaled tick. The tick comes from a fixed clock divider. Three active compare values shape the waveform:

- a low threshold: output A is high while the count is below it;
- a high threshold: output B is high while the count is at or above it;
- a turning value: the counter reverses direction there.

The gaps between the two thresholds form symmetric dead-time. A fourth compare value has no effect on either output. It only places an ADC synchronisation pulse within the rising half of the cycle.

Software writes new compare values into a shadow bank through a small write port. It then raises an update request. The whole bank is copied into the active set together at the next cycle boundary, so no period mixes old and new settings. A restart pulse aborts the running cycle, loads the shadow bank at once and begins a fresh cycle. The run input gates the generator: dropping it lets the current cycle finish and then parks both outputs low.

Top module: `cac_pwm_gen`

## Requirements
- R1: A tick occurs every DIV clocks. One full output period lasts 2*(TOP+1) ticks. The counter passes 0..TOP going up and then TOP..0 going down, holding each value for one tick.
- R2: Output A is high for exactly 2*SA ticks per period: the ticks where the count is below SA.
- R3: Output B is high for exactly 2*(TOP-SB+1) ticks per period: the ticks where the count is at least SB.
- R4: With SA <= SB, the outputs are never high together, and each of the two dead gaps lasts SB-SA ticks. SA equal to SB gives zero dead-time.
- R5: TOP = 0 is legal and gives a 2-tick period.
- R6: adc_trig is high for exactly one tick per period, during the up-counting tick whose count equals the ADC compare value. That value does not change out_a or out_b.
- R7: wr_en writes wr_data into the shadow slot chosen by wr_sel (0 = SA, 1 = SB, 2 = TOP, 3 = ADC compare). Shadow writes leave the outputs unchanged until a load occurs.
- R8: upd_req sets upd_pending. The shadow bank is copied into the active set only at a cycle boundary while upd_pending is set, and that copy clears upd_pending.
- R9: A restart pulse loads the shadow bank immediately, clears upd_pending and the prescaler, and starts a new cycle at count 0 counting up if run is high.
- R10: When run falls, the current cycle completes and then both outputs stay low. When run rises again, a new cycle starts from count 0.
- R11: After reset, out_a, out_b, adc_trig and upd_pending are all low, and the reset compare values are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables the generator |
| restart | input | 1 | Pulse: abort the cycle, load the shadow bank, restart |
| upd_req | input | 1 | Pulse: request a shadow-to-active load at the cycle end |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 2 | Shadow slot: 0 SA, 1 SB, 2 TOP, 3 ADC |
| wr_data | input | CNT_W | Shadow write value |
| out_a | output | 1 | First PWM output |
| out_b | output | 1 | Second (complementary) PWM output |
| adc_trig | output | 1 | ADC synchronisation pulse, one tick wide |
| upd_pending | output | 1 | Update request waiting for the cycle end |

## Verification
The generator is run with three settings. The first is a wide dead-time. The second is equal thresholds, which separates the dead-time arithmetic from the on-time arithmetic. The third is the degenerate TOP = 0 period, which exposes off-by-one errors at the turning point. Measurement windows span a whole number of periods, so high-time counts and trigger-pulse counts verify each formula in its own right. Shadow writes made without a request show whether the active set leaks early. Restart and run-low sequences show whether loading and stopping follow the cycle boundary. A tick-level reference model is compared on every clock, which catches any misplaced edge.

// File: rtl/cac_pwm_pkg.sv
// Shared encodings for the center-aligned PWM generator.
// Assumes: the wr_sel encoding below is the one software uses.
package cac_pwm_pkg;
    typedef enum logic [1:0] {
        SEL_SA  = 2'd0,
        SEL_SB  = 2'd1,
        SEL_TOP = 2'd2,
        SEL_ADC = 2'd3
    } cmp_sel_e;
endpackage

// File: rtl/cac_prescaler.sv
// Clock divider: produces a one-clock tick every DIV clocks.
// Assumes: DIV >= 1; restart re-phases the divider so that a fresh cycle starts clean.
module cac_prescaler #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PSC_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PSC_W-1:0] LAST = PSC_W'(DIV - 1);

    logic [PSC_W-1:0] psc;

    assign tick = (psc == LAST);

    // Divider count, wrapping at DIV-1 and cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) psc <= '0;
        else if (tick)         psc <= '0;
        else                   psc <= psc + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R1: two ticks are never adjacent when dividing
            a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cac_regset.sv
// Shadow and active compare banks with the update-pending flag.
// Assumes: load_now is asserted only at a cycle boundary or on restart.
module cac_regset
    import cac_pwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RST_SA  = 2,
    parameter int RST_SB  = 4,
    parameter int RST_TOP = 7,
    parameter int RST_ADC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd_req,
    input  logic             load_now,
    output logic [CNT_W-1:0] act_sa,
    output logic [CNT_W-1:0] act_sb,
    output logic [CNT_W-1:0] act_top,
    output logic [CNT_W-1:0] act_adc,
    output logic             pending
);
    logic [CNT_W-1:0] sh_sa, sh_sb, sh_top, sh_adc;

    // Shadow bank: software writes land here only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_sa  <= CNT_W'(RST_SA);
            sh_sb  <= CNT_W'(RST_SB);
            sh_top <= CNT_W'(RST_TOP);
            sh_adc <= CNT_W'(RST_ADC);
        end else if (wr_en) begin
            case (cmp_sel_e'(wr_sel))
                SEL_SA:  sh_sa  <= wr_data;
                SEL_SB:  sh_sb  <= wr_data;
                SEL_TOP: sh_top <= wr_data;
                default: sh_adc <= wr_data;
            endcase
        end
    end

    // Active bank: copied from the shadow bank as one set on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sa  <= CNT_W'(RST_SA);
            act_sb  <= CNT_W'(RST_SB);
            act_top <= CNT_W'(RST_TOP);
            act_adc <= CNT_W'(RST_ADC);
        end else if (load_now) begin
            act_sa  <= sh_sa;
            act_sb  <= sh_sb;
            act_top <= sh_top;
            act_adc <= sh_adc;
        end
    end

    // Pending flag: set by a request, cleared by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= upd_req | (pending & ~load_now);
    end

    // R7: the active bank changes only through a load
    a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_now |=> $stable({act_sa, act_sb, act_top, act_adc}));
    // R8: a load without a new request leaves nothing pending
    a_r8_pending_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && !upd_req) |=> !pending);
endmodule

// File: rtl/cac_updown_counter.sv
// Up/down counter for one center-aligned cycle, with run gating and restart.
// Assumes: top does not change in the middle of a cycle; it changes only when the count is 0.
module cac_updown_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             active,
    output logic             boundary
);
    // A cycle boundary is the tick that ends a cycle, or the tick that starts one from idle.
    assign boundary = tick && (active ? (dir_down && cnt == '0) : run);

    // Counter, direction and run state, advancing once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            dir_down <= 1'b0;
            active   <= 1'b0;
        end else if (restart) begin
            cnt      <= '0;
            dir_down <= 1'b0;
            active   <= run;
        end else if (tick) begin
            if (!active || (dir_down && cnt == '0)) begin
                cnt      <= '0;
                dir_down <= 1'b0;
                active   <= run;
            end else if (!dir_down) begin
                if (cnt == top) dir_down <= 1'b1;
                else            cnt      <= cnt + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R1: while running, the count never passes the turning value
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= top));
    // R1: the count holds still between ticks
    a_r1_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt));
    // R9: restart always lands on count 0, counting up
    a_r9_restart_origin: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && !dir_down));
endmodule

// File: rtl/cac_pwm_gen.sv
// Top: center-aligned complementary PWM with a shadowed compare set and an ADC sync pulse.
// Assumes: software keeps SA <= SB <= TOP + 1 for a non-overlapping waveform.
module cac_pwm_gen #(
    parameter int CNT_W   = 8,
    parameter int DIV     = 2,
    parameter int RST_SA  = 2,
    parameter int RST_SB  = 4,
    parameter int RST_TOP = 7,
    parameter int RST_ADC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             upd_req,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             out_a,
    output logic             out_b,
    output logic             adc_trig,
    output logic             upd_pending
);
    logic             tick, boundary, active, dir_down, load_now;
    logic [CNT_W-1:0] cnt, act_sa, act_sb, act_top, act_adc;

    cac_prescaler #(.DIV(DIV)) u_psc (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    cac_regset #(
        .CNT_W(CNT_W), .RST_SA(RST_SA), .RST_SB(RST_SB),
        .RST_TOP(RST_TOP), .RST_ADC(RST_ADC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_req(upd_req), .load_now(load_now),
        .act_sa(act_sa), .act_sb(act_sb), .act_top(act_top),
        .act_adc(act_adc), .pending(upd_pending)
    );

    cac_updown_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .run(run),
        .top(act_top), .cnt(cnt), .dir_down(dir_down), .active(active),
        .boundary(boundary)
    );

    // Load on restart, or at a cycle boundary when a request is waiting.
    assign load_now = restart | (boundary & upd_pending);

    // Output decode from the counter state and the active compare set.
    always_comb begin
        out_a    = active && (cnt < act_sa);
        out_b    = active && (cnt >= act_sb);
        adc_trig = active && !dir_down && (cnt == act_adc);
    end

    // R6: the sync pulse lasts a single tick
    a_r6_adc_single: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_trig && tick && !restart) |=> !adc_trig);
    // R10: an idle generator drives nothing
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(out_a || out_b || adc_trig));
endmodule

// File: tb/cac_pwm_gen_tb.sv
module cac_pwm_gen_tb;
    localparam int CNT_W = 8;
    localparam int DIV   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, restart = 1'b0, upd_req = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic out_a, out_b, adc_trig, upd_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cac_pwm_gen #(.CNT_W(CNT_W), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .upd_req(upd_req), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .out_a(out_a), .out_b(out_b), .adc_trig(adc_trig),
        .upd_pending(upd_pending)
    );

    // Tick-level behavioural reference model.
    int m_psc, m_cnt, m_down, m_act, m_pend;
    int sh[4];
    int ac[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_psc = 0; m_cnt = 0; m_down = 0; m_act = 0; m_pend = 0;
            sh[0] = 2; sh[1] = 4; sh[2] = 7; sh[3] = 0;
            ac = sh;
        end else begin
            bit tk, bnd, ld;
            tk  = (m_psc == DIV - 1);
            bnd = tk && (m_act != 0 ? (m_down != 0 && m_cnt == 0) : run);
            ld  = restart || (bnd && m_pend != 0);
            if (ld) ac = sh;
            if (wr_en) sh[wr_sel] = int'(wr_data);
            m_pend = (upd_req || (m_pend != 0 && !ld)) ? 1 : 0;
            if (restart) begin
                m_cnt = 0; m_down = 0; m_act = run;
            end else if (tk) begin
                if (m_act == 0 || (m_down != 0 && m_cnt == 0)) begin
                    m_cnt = 0; m_down = 0; m_act = run;
                end else if (m_down == 0) begin
                    if (m_cnt == ac[2]) m_down = 1; else m_cnt++;
                end else m_cnt--;
            end
            m_psc = (restart || tk) ? 0 : m_psc + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Every-clock comparison against the model (R2/R3/R6/R8).
    always @(negedge clk) begin
        if (rst_n) begin
            int ea, eb, ed;
            ea = (m_act != 0 && m_cnt < ac[0]) ? 1 : 0;
            eb = (m_act != 0 && m_cnt >= ac[1]) ? 1 : 0;
            ed = (m_act != 0 && m_down == 0 && m_cnt == ac[3]) ? 1 : 0;
            check("R2 model out_a", int'(out_a), ea);
            check("R3 model out_b", int'(out_b), eb);
            check("R6 model adc_trig", int'(adc_trig), ed);
            check("R8 model upd_pending", int'(upd_pending), m_pend);
        end
    end

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = CNT_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk); upd_req = 1'b1;
        @(negedge clk); upd_req = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    // Count high clocks over k whole periods; the window is periodic, so alignment does not matter.
    task automatic measure(input int top, input int sa, input int sb, input int k);
        int na = 0, nb = 0, nd = 0, np = 0, prev;
        int len = 2 * (top + 1) * DIV * k;
        prev = int'(adc_trig);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (out_a) na++;
            if (out_b) nb++;
            if (!out_a && !out_b) nd++;
            if (out_a && out_b) nd += 1000;
            if (adc_trig && prev == 0) np++;
            prev = int'(adc_trig);
        end
        check("R1 period (sync pulses per window)", np, k);
        check("R2 out_a high clocks", na, 2 * sa * DIV * k);
        check("R3 out_b high clocks", nb, 2 * (top - sb + 1) * DIV * k);
        check("R4 dead clocks, no overlap", nd, 2 * (sb - sa) * DIV * k);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R11 reset out_a", int'(out_a), 0);
        check("R11 reset out_b", int'(out_b), 0);
        check("R11 reset adc_trig", int'(adc_trig), 0);
        check("R11 reset upd_pending", int'(upd_pending), 0);
        rst_n = 1'b1;
        @(negedge clk); run = 1'b1;
        repeat (80) @(negedge clk);
        measure(7, 2, 4, 3);

        // R7: shadow writes without a request do not reach the outputs.
        wr(0, 1); wr(1, 5); wr(2, 9); wr(3, 3);
        repeat (40) @(negedge clk);
        measure(7, 2, 4, 3);

        // R8: request, flag set, then cleared at the cycle end with the new set live.
        pulse_upd();
        check("R8 pending after request", int'(upd_pending), 1);
        repeat (80) @(negedge clk);
        check("R8 pending cleared after load", int'(upd_pending), 0);
        measure(9, 1, 5, 3);

        // R5: minimal period loaded through restart.
        wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
        pulse_restart();
        check("R9 restart loads immediately, out_b", int'(out_b), 1);
        repeat (20) @(negedge clk);
        measure(0, 0, 0, 5);
        check("R5 minimal period out_b always high", int'(out_b), 1);

        // R4: equal thresholds give zero dead-time.
        wr(0, 3); wr(1, 3); wr(2, 5); wr(3, 2);
        pulse_upd();
        repeat (60) @(negedge clk);
        measure(5, 3, 3, 2);

        // R9: restart in mid-cycle with a pending request.
        wr(0, 2); wr(1, 4); wr(2, 7); wr(3, 1);
        pulse_upd();
        repeat (3) @(negedge clk);
        pulse_restart();
        check("R9 restart starts at count 0, out_a high", int'(out_a), 1);
        check("R9 restart clears pending", int'(upd_pending), 0);
        repeat (70) @(negedge clk);
        measure(7, 2, 4, 2);

        // R10: run low finishes the cycle, then everything stays low.
        @(negedge clk); run = 1'b0;
        repeat (2 * 8 * DIV + 4) @(negedge clk);
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (out_a || out_b || adc_trig) hi++;
            end
            check("R10 outputs low after stop", hi, 0);
        end
        @(negedge clk); run = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 restart from count 0, out_a high", int'(out_a), 1);
        repeat (60) @(negedge clk);
        measure(7, 2, 4, 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule